// File: doc/BRIEF.md
# Calibrated Real-Time Clock Prescaler

This block turns a stream of clock-enable pulses at 32768 per second into a one-second tick and a one-minute strobe. The rate is trimmed digitally instead of with a trimming capacitor. A 5-bit magnitude and a sign bit pick how many minutes of a repeating 64-minute window get one corrected second. A corrected second is either shortened (the clock runs faster) or lengthened (the clock runs slower). The correction is applied at the divide-by-256 stage of the chain.

The block also produces a 512 Hz square wave for measuring the crystal. Calibration never changes this wave. A small mux picks what drives the shared interrupt line: a pending alarm or watchdog interrupt, or the test wave. The test wave is only passed when the interrupt sources cannot claim the line.

A stop input freezes the whole chain. Releasing it resumes counting from the held state. All sizes are parameters. The defaults give 256 enables per stage, 128 stages per second, 60 seconds per minute and 64 minutes per correction window.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: While the synchronous reset is high, `sec_tick_o`, `min_tick_o`, `test_wave_o` and `irq_o` are 0. After reset the first second starts from an empty divider, and the window starts at minute 0, second 0.
- R2: An uncorrected second lasts exactly PRE_STAGE*STAGES_PER_SEC accepted enables (32768 by default). An enable is accepted only when `cnt_en_i` is 1 and `stop_i` is 0. `sec_tick_o` is a one-cycle pulse, one cycle after the edge that accepts the last enable of the second.
- R3: `min_tick_o` pulses in the same cycle as the `sec_tick_o` that ends the last second (count SECS_PER_MIN-1) of each minute, and at no other time.
- R4: With magnitude N on `cal_mag_i` (unsigned, 0 to 31), exactly the first second (second 0) of each of minutes 0 to 2N-1 is corrected. Minutes are counted modulo MIN_PER_CYCLE (64), so the pattern repeats every window. N=0 gives no correction.
- R5: With `cal_pos_i`=1, each corrected second is PRE_STAGE (256) enables shorter than nominal.
- R6: With `cal_pos_i`=0, each corrected second is PRE_STAGE/2 (128) enables longer than nominal.
- R7: While `stop_i` is 1 no tick is produced, and neither the divider nor the test wave advances. After release, counting continues from the held count, so the total enables per second are unchanged.
- R8: `test_wave_o` is a 50% square wave that toggles every TICKS/(2*TEST_HZ) accepted enables (every 32 by default). This holds under any calibration setting.
- R9: `irq_o` follows `test_wave_o`, one cycle later, when all of the following hold: `stop_i`=0, `ftest_en_i`=1, `alarm_ie_i`=0, and either `wd_steer_i`=1 or `wd_zero_i`=1.
- R10: `irq_pend_i`=1 drives `irq_o` to 1 on the next cycle, whatever the test-wave settings are.
- R11: With `irq_pend_i`=0 and the R9 condition false, `irq_o` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cnt_en_i | input | 1 | One pulse per oscillator count |
| stop_i | input | 1 | Freeze the divider and the test wave |
| cal_mag_i | input | CAL_W | Correction magnitude (number of minute pairs) |
| cal_pos_i | input | 1 | 1: shorten corrected seconds; 0: lengthen them |
| ftest_en_i | input | 1 | Request the test wave on the interrupt line |
| alarm_ie_i | input | 1 | Alarm interrupt enable; blocks the test wave |
| wd_steer_i | input | 1 | Watchdog steered away from the interrupt line |
| wd_zero_i | input | 1 | Watchdog setting is all zero |
| irq_pend_i | input | 1 | Active alarm or watchdog interrupt |
| sec_tick_o | output | 1 | One-second pulse |
| min_tick_o | output | 1 | One-minute pulse |
| test_wave_o | output | 1 | 512 Hz square wave |
| irq_o | output | 1 | Shared interrupt output, active high |

## Verification
A wrong divider count shows up at the end of the second it corrupts, as a tick interval off by a fixed number of enables. A wrong minute or window count stays hidden until the first second of some minute. It then appears as a corrected second in the wrong minute, or a missing one, so a full 64-minute window plus the wrap into the next is run with the widest magnitude. The test wave and the interrupt mux are compared every cycle, so a routing error is visible within one cycle and a wave-counter error within one half period.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  // kind of correction applied to the second now being counted
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_SHORT = 2'd1,
    ADJ_LONG  = 2'd2
  } adj_e;
endpackage

// File: rtl/rtc_div_chain.sv
module rtc_div_chain import rtc_cal_pkg::*; #(
  parameter int STAGE_CNT = 256,
  parameter int STAGES    = 128
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cnt_en_i,
  input  logic stop_i,
  input  adj_e adj_i,
  output logic tick_o
);
  localparam int LONG_LIM = STAGE_CNT + STAGE_CNT / 2 - 1;
  localparam int FW = $clog2(LONG_LIM + 1);
  localparam int CW = (STAGES > 1) ? $clog2(STAGES) : 1;

  logic [FW-1:0] fine_q;
  logic [CW-1:0] coarse_q;
  logic [FW-1:0] fine_lim;
  logic [CW-1:0] coarse_lim;
  logic adv, fine_wrap, coarse_wrap;

  assign adv = cnt_en_i & ~stop_i;

  // long second: the first stage of the second runs half a stage longer
  // short second: one whole stage is dropped
  always_comb begin
    fine_lim   = FW'(STAGE_CNT - 1);
    coarse_lim = CW'(STAGES - 1);
    if (adj_i == ADJ_LONG && coarse_q == '0) fine_lim = FW'(LONG_LIM);
    if (adj_i == ADJ_SHORT) coarse_lim = CW'(STAGES - 2);
  end

  assign fine_wrap   = fine_q >= fine_lim;
  assign coarse_wrap = coarse_q >= coarse_lim;
  assign tick_o      = adv & fine_wrap & coarse_wrap;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fine_q   <= '0;
      coarse_q <= '0;
    end else if (adv) begin
      if (fine_wrap) begin
        fine_q   <= '0;
        coarse_q <= coarse_wrap ? '0 : coarse_q + 1'b1;
      end else begin
        fine_q <= fine_q + 1'b1;
      end
    end
  end

  p_fine_range_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(fine_q) <= LONG_LIM);
  p_stop_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_i |=> ($stable(fine_q) && $stable(coarse_q)));
endmodule

// File: rtl/rtc_cal_window.sv
module rtc_cal_window import rtc_cal_pkg::*; #(
  parameter int SECS  = 60,
  parameter int CYC   = 64,
  parameter int CAL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic [CAL_W-1:0] mag_i,
  input  logic             sign_i,
  output adj_e             adj_o,
  output logic             min_wrap_o
);
  localparam int SW = (SECS > 1) ? $clog2(SECS) : 1;
  localparam int MW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [SW-1:0] sec_q;
  logic [MW-1:0] min_q;
  logic last_sec;

  assign last_sec   = sec_q == SW'(SECS - 1);
  assign min_wrap_o = tick_i & last_sec;

  // only second 0 of the first 2*mag minutes of the window is corrected
  always_comb begin
    adj_o = ADJ_NONE;
    if (sec_q == '0 && int'(min_q) < 2 * int'(mag_i))
      adj_o = sign_i ? ADJ_SHORT : ADJ_LONG;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sec_q <= '0;
      min_q <= '0;
    end else if (tick_i) begin
      if (last_sec) begin
        sec_q <= '0;
        min_q <= (min_q == MW'(CYC - 1)) ? '0 : min_q + 1'b1;
      end else begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end

  p_sec_range_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(sec_q) < SECS);
  p_min_range_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(min_q) < CYC);
endmodule

// File: rtl/rtc_test_wave.sv
module rtc_test_wave #(
  parameter int HALF = 32
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic adv_i,
  output logic wave_o
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [TW-1:0] cnt_q;
  logic wrap;

  assign wrap = cnt_q == TW'(HALF - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      wave_o <= 1'b0;
    end else if (adv_i) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) wave_o <= ~wave_o;
    end
  end

  p_wave_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !adv_i |=> $stable(wave_o));
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler import rtc_cal_pkg::*; #(
  parameter int PRE_STAGE      = 256,
  parameter int STAGES_PER_SEC = 128,
  parameter int SECS_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE  = 64,
  parameter int CAL_W          = 5,
  parameter int TEST_HZ        = 512
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             cnt_en_i,
  input  logic             stop_i,
  input  logic [CAL_W-1:0] cal_mag_i,
  input  logic             cal_pos_i,
  input  logic             ftest_en_i,
  input  logic             alarm_ie_i,
  input  logic             wd_steer_i,
  input  logic             wd_zero_i,
  input  logic             irq_pend_i,
  output logic             sec_tick_o,
  output logic             min_tick_o,
  output logic             test_wave_o,
  output logic             irq_o
);
  localparam int TICKS     = PRE_STAGE * STAGES_PER_SEC;
  localparam int TEST_HALF = TICKS / (2 * TEST_HZ);

  adj_e adj;
  logic tick_now, min_wrap, wave, wave_route;

  rtc_div_chain #(.STAGE_CNT(PRE_STAGE), .STAGES(STAGES_PER_SEC)) i_div (
    .clk_i(clk_i), .rst_i(rst_i), .cnt_en_i(cnt_en_i), .stop_i(stop_i),
    .adj_i(adj), .tick_o(tick_now));

  rtc_cal_window #(.SECS(SECS_PER_MIN), .CYC(MIN_PER_CYCLE), .CAL_W(CAL_W)) i_win (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_now), .mag_i(cal_mag_i),
    .sign_i(cal_pos_i), .adj_o(adj), .min_wrap_o(min_wrap));

  rtc_test_wave #(.HALF(TEST_HALF)) i_wave (
    .clk_i(clk_i), .rst_i(rst_i), .adv_i(cnt_en_i & ~stop_i), .wave_o(wave));

  assign test_wave_o = wave;
  assign wave_route  = ~stop_i & ftest_en_i & ~alarm_ie_i & (wd_steer_i | wd_zero_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sec_tick_o <= 1'b0;
      min_tick_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      sec_tick_o <= tick_now;
      min_tick_o <= min_wrap;
      irq_o      <= irq_pend_i | (wave_route & wave);
    end
  end

  p_min_with_sec_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    min_tick_o |-> sec_tick_o);
  p_tick_needs_count_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sec_tick_o) |-> $past(cnt_en_i && !stop_i));
  p_pend_wins_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_pend_i |=> irq_o);
  p_quiet_line_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (!irq_pend_i && (!ftest_en_i || alarm_ie_i || stop_i)) |=> !irq_o);
  p_stopped_no_tick_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    stop_i |=> !sec_tick_o);
endmodule

// File: tb/test_rtc_cal_prescaler.sv
module test_rtc_cal_prescaler;
  localparam int P_STAGE = 8, P_STAGES = 16, P_SECS = 4, P_CYC = 64, P_THZ = 8;
  localparam int NOM  = P_STAGE * P_STAGES;
  localparam int HALF = NOM / (2 * P_THZ);

  logic clk = 1'b0, rst = 1'b1, cnt_en = 1'b0, stop = 1'b0, cal_pos = 1'b0;
  logic ftest = 1'b0, alarm_ie = 1'b0, wd_steer = 1'b0, wd_zero = 1'b0, pend = 1'b0;
  logic [4:0] mag = 5'd0;
  logic sec_tick, min_tick, test_wave, irq;

  rtc_cal_prescaler #(.PRE_STAGE(P_STAGE), .STAGES_PER_SEC(P_STAGES),
    .SECS_PER_MIN(P_SECS), .MIN_PER_CYCLE(P_CYC), .CAL_W(5), .TEST_HZ(P_THZ))
  i_rtc_cal_prescaler (
    .clk_i(clk), .rst_i(rst), .cnt_en_i(cnt_en), .stop_i(stop), .cal_mag_i(mag),
    .cal_pos_i(cal_pos), .ftest_en_i(ftest), .alarm_ie_i(alarm_ie),
    .wd_steer_i(wd_steer), .wd_zero_i(wd_zero), .irq_pend_i(pend),
    .sec_tick_o(sec_tick), .min_tick_o(min_tick), .test_wave_o(test_wave), .irq_o(irq));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int exp_len[$];
  bit exp_min[$];
  string exp_tag[$];
  int sec_idx = 0, en_mode = 0, cyc = 0;
  int acc = 0, wacc = 0, stop_ticks = 0, irq_toggles = 0;
  bit wave_prev = 1'b0, last_irq = 1'b0, sb_on = 1'b0, stop_win = 1'b0;
  bit irq_chk = 1'b0, exp_sel = 1'b0;
  string irq_tag = "R9";

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // enable driver
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    cnt_en = (en_mode == 0) ? 1'b1 : (cyc % 3 != 0);
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (rst) begin
      acc = 0; wacc = 0; wave_prev = 1'b0; last_irq = 1'b0;
    end else begin
      if (sec_tick) begin
        if (stop_win) stop_ticks++;
        if (sb_on) begin
          if (exp_len.size() == 0) chk(1'b0, "R2 unexpected tick", 1, 0);
          else begin
            int e; bit m; string t;
            e = exp_len.pop_front(); m = exp_min.pop_front(); t = exp_tag.pop_front();
            chk(acc == e, t, acc, e);
            chk(min_tick == m, "R3 minute strobe", int'(min_tick), int'(m));
          end
        end
        acc = 0;
      end else if (min_tick) chk(1'b0, "R3 strobe without tick", 1, 0);
      if (test_wave != wave_prev) begin
        chk(wacc == HALF, "R8 test wave half period", wacc, HALF);
        wacc = 0;
      end
      if (irq_chk) begin
        bit e;
        e = pend | (exp_sel & wave_prev);
        chk(irq == e, irq_tag, int'(irq), int'(e));
        if (irq != last_irq) irq_toggles++;
      end
      last_irq = irq;
      if (cnt_en && !stop) begin acc++; wacc++; end
      wave_prev = test_wave;
    end
  end

  task automatic do_reset();
    @(posedge clk); #2;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    sec_idx = 0;
    exp_len.delete(); exp_min.delete(); exp_tag.delete();
  endtask

  task automatic run_seconds(input int n);
    for (int i = 0; i < n; i++) begin
      int s, m; bit aff;
      s = sec_idx % P_SECS;
      m = (sec_idx / P_SECS) % P_CYC;
      aff = (s == 0) && (m < 2 * int'(mag));
      if (aff && cal_pos) begin exp_len.push_back(NOM - P_STAGE); exp_tag.push_back("R4 R5 short second"); end
      else if (aff) begin exp_len.push_back(NOM + P_STAGE / 2); exp_tag.push_back("R4 R6 long second"); end
      else begin exp_len.push_back(NOM); exp_tag.push_back("R2 R4 nominal second"); end
      exp_min.push_back(s == P_SECS - 1);
      sec_idx++;
    end
    while (exp_len.size() != 0) @(negedge clk);
  endtask

  task automatic irq_case(input bit stp, input bit ft, input bit aie, input bit ws,
                          input bit wz, input bit pnd, input string tag);
    irq_chk = 1'b0;
    @(posedge clk); #2;
    stop = stp; ftest = ft; alarm_ie = aie; wd_steer = ws; wd_zero = wz; pend = pnd;
    exp_sel = !stp && ft && !aie && (ws || wz);
    irq_tag = tag;
    repeat (3) @(posedge clk);
    #2;
    irq_toggles = 0;
    irq_chk = 1'b1;
    repeat (40) @(posedge clk);
    #2;
    irq_chk = 1'b0;
    if (exp_sel && !pnd) chk(irq_toggles >= 4, {tag, " wave routed"}, irq_toggles, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    sb_on = 1'b1;
    // R2 R3: no correction
    mag = 5'd0; cal_pos = 1'b0; en_mode = 0;
    run_seconds(10);
    // R1: outputs cleared while reset is held, taken mid-run
    ftest = 1'b1; wd_steer = 1'b1; pend = 1'b1;
    repeat (20) @(posedge clk);
    @(posedge clk); #2; rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(sec_tick == 1'b0, "R1 sec tick in reset", int'(sec_tick), 0);
    chk(min_tick == 1'b0, "R1 min tick in reset", int'(min_tick), 0);
    chk(test_wave == 1'b0, "R1 wave in reset", int'(test_wave), 0);
    chk(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
    ftest = 1'b0; wd_steer = 1'b0; pend = 1'b0;
    // R4 R5: positive correction, sparse enables
    mag = 5'd2; cal_pos = 1'b1; en_mode = 1;
    do_reset();
    run_seconds(24);
    // R4 R6: widest negative correction over a full window and its wrap
    mag = 5'd31; cal_pos = 1'b0; en_mode = 0;
    do_reset();
    run_seconds(P_SECS * (P_CYC + 2));
    // R7: stop freezes and resumes
    mag = 5'd1; cal_pos = 1'b1;
    do_reset();
    run_seconds(1);
    repeat (40) @(posedge clk);
    #2; stop = 1'b1; stop_win = 1'b1;
    repeat (300) @(posedge clk);
    #2;
    chk(stop_ticks == 0, "R7 ticks while stopped", stop_ticks, 0);
    stop = 1'b0; stop_win = 1'b0;
    run_seconds(9);
    // R9 R10 R11: interrupt line routing
    sb_on = 1'b0;
    mag = 5'd0;
    do_reset();
    irq_case(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 steer");
    irq_case(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R9 wd zero");
    irq_case(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11 wd armed");
    irq_case(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R11 alarm ie");
    irq_case(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R11 ftest off");
    irq_case(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R11 stopped");
    irq_case(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R10 pending");
    irq_case(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R10 pending only");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule